// File: doc/BRIEF.md
# Interrupt Sequencer for a 16-bit CPU

This block runs interrupt entry and exit for a small 16-bit processor. It watches an external request line on every clock edge. When interrupts are enabled it records a request in a hidden pending flag, and it leaves the running instruction to complete. At the next instruction boundary, the instruction sequencer raises a fetch-request strobe. If a request is pending, the block takes over in place of the fetch. It first runs a two-cycle acknowledge handshake that picks up an identifier byte from the I/O bus. It then pushes the return address onto the memory stack, reads the handler address from a fixed vector word at the top of memory, and hands that address to the instruction pointer.

The same entry path serves a software interrupt instruction, whose immediate operand becomes the identifier. The return-from-interrupt instruction pops the saved address back into the instruction pointer and clears the identifier. The stack pointer, the instruction pointer and the enable flag are held in the CPU register file. The block reads their current values and returns updates through write strobes. Memory is one word wide, with a synchronous read of one cycle.

Top module: `int_sequencer`

## Requirements
- R1: After synchronous reset, `ira_o`, `busy_o`, `int_take_o`, `mem_req_o`, `ip_wr_o`, `sp_wr_o` and `ie_clr_o` are low, `iid_o` is zero and no request is pending.
- R2: `irq_i` is sampled on each rising edge. A high sample with `ie_i` high, while the block is idle, marks a request as pending. A high sample while `ie_i` is low is dropped: enabling interrupts later does not revive it.
- R3: A pending request is taken only in a cycle with `fetch_req_i` high. `int_take_o` is high in that cycle. Without `fetch_req_i`, `ira_o` stays low however long the request waits.
- R4: `ira_o` is high for exactly the two cycles that follow the take cycle. Memory is idle in both cycles. Only the bus value in the second cycle is captured: `iid_o` becomes `io_data_i` zero-extended to 16 bits, and the value in the first cycle is ignored.
- R5: On entry the block writes `next_ip_i` to memory at address SP−2, and writes SP−2 back through `sp_wr_o`/`sp_wdata_o` in the same cycle.
- R6: On the next cycle it reads the word at the vector address (default 0xFFFC). Two cycles later it drives `ip_wr_o` with that word, and `busy_o` falls in that same cycle. `busy_o` is high from the first acknowledge cycle until then, and also for the whole of a software entry or a return.
- R7: Every entry pulses `ie_clr_o` for one cycle, in the first cycle of the sequence.
- R8: `swi_i` with `ie_i` high loads `swi_id_i` into `iid_o` and starts the push of R5 directly, with no acknowledge cycles. The vector load of R6 follows.
- R9: `swi_i` with `ie_i` low has no effect: `busy_o`, `mem_req_o` and `ira_o` stay low and `iid_o` keeps its value.
- R10: `iret_i` clears `iid_o` and reads memory at SP. Two cycles later it drives `ip_wr_o` with the word read, and `sp_wr_o` with SP+2.
- R11: While `irq_i` stays high across the take and the whole service, only one entry occurs. The cleared enable flag keeps further fetch boundaries from being taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_i | input | 1 | External interrupt request |
| fetch_req_i | input | 1 | Instruction boundary: the next fetch would start now |
| swi_i | input | 1 | Software interrupt instruction executes |
| swi_id_i | input | 16 | Immediate operand of the software interrupt |
| iret_i | input | 1 | Return-from-interrupt instruction executes |
| ie_i | input | 1 | Current interrupt-enable flag |
| sp_i | input | 16 | Current stack pointer |
| next_ip_i | input | 16 | Address of the next instruction |
| io_data_i | input | 8 | I/O data bus |
| mem_rdata_i | input | 16 | Memory read word, valid one cycle after the request |
| int_take_o | output | 1 | Pending request taken in place of the fetch |
| ira_o | output | 1 | Interrupt acknowledge |
| busy_o | output | 1 | Sequence in progress; instruction sequencer stalls |
| ie_clr_o | output | 1 | Clear the interrupt-enable flag |
| iid_o | output | 16 | Interrupt identifier register |
| sp_wr_o | output | 1 | Stack pointer write strobe |
| sp_wdata_o | output | 16 | New stack pointer |
| ip_wr_o | output | 1 | Instruction pointer write strobe |
| ip_wdata_o | output | 16 | New instruction pointer |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 16 | Memory byte address |
| mem_wdata_o | output | 16 | Memory write word |

## Verification
A corrupted pending flag has two visible symptoms at the ports. `int_take_o` rises on a fetch boundary where no enabled request was seen. Or a held request produces a second acknowledge pair after the enable flag has been cleared. Either shows within one cycle of the next `fetch_req_i`. A state register that slips a step shows within the same service. `ira_o` then lasts one or three cycles, or the wrong I/O byte lands in `iid_o`. Or the vector read, the push address or the `ip_wr_o` pulse moves by a cycle. The bench therefore checks every cycle of each sequence against a cycle count taken from the requirements.

// File: rtl/intseq_pkg.sv
package intseq_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_ACK1,
    S_ACK2,
    S_PUSH,
    S_VREQ,
    S_VDATA,
    S_RREQ,
    S_RDATA
  } seq_state_t;
endpackage

// File: rtl/intseq_pending.sv
module intseq_pending (
  input  logic clk,
  input  logic rst,
  input  logic irq_i,
  input  logic ie_i,
  input  logic idle_i,
  input  logic take_i,
  output logic pend_o
);
  // Hidden queued flag: set only when idle and not being taken this cycle,
  // so a held request cannot re-queue during its own service.
  always_ff @(posedge clk) begin
    if (rst)                                    pend_o <= 1'b0;
    else if (take_i)                            pend_o <= 1'b0;
    else if (irq_i && ie_i && idle_i)           pend_o <= 1'b1;
  end
endmodule

// File: rtl/intseq_fsm.sv
module intseq_fsm
  import intseq_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DW       = 16,
  parameter int IDW      = 8,
  parameter int STEP     = 2,
  parameter logic [AW-1:0] VEC_ADDR = 16'hFFFC
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take_i,
  input  logic          swi_i,
  input  logic [DW-1:0] swi_id_i,
  input  logic          iret_i,
  input  logic          ie_i,
  input  logic [AW-1:0] sp_i,
  input  logic [AW-1:0] next_ip_i,
  input  logic [IDW-1:0] io_data_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          idle_o,
  output logic          ira_o,
  output logic          busy_o,
  output logic          ie_clr_o,
  output logic [DW-1:0] iid_o,
  output logic          sp_wr_o,
  output logic [AW-1:0] sp_wdata_o,
  output logic          ip_wr_o,
  output logic [AW-1:0] ip_wdata_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o
);
  localparam logic [AW-1:0] STEP_W = AW'(STEP);

  seq_state_t state_q;
  logic [AW-1:0] sp_dec, sp_inc;

  assign sp_dec = sp_i - STEP_W;
  assign sp_inc = sp_i + STEP_W;
  assign idle_o = (state_q == S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= S_IDLE;
      ira_o       <= 1'b0;
      busy_o      <= 1'b0;
      ie_clr_o    <= 1'b0;
      iid_o       <= '0;
      sp_wr_o     <= 1'b0;
      sp_wdata_o  <= '0;
      ip_wr_o     <= 1'b0;
      ip_wdata_o  <= '0;
      mem_req_o   <= 1'b0;
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
    end else begin
      ie_clr_o  <= 1'b0;
      sp_wr_o   <= 1'b0;
      ip_wr_o   <= 1'b0;
      mem_req_o <= 1'b0;
      mem_we_o  <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (take_i) begin
            state_q  <= S_ACK1;
            ira_o    <= 1'b1;
            busy_o   <= 1'b1;
            ie_clr_o <= 1'b1;
          end else if (swi_i && ie_i) begin
            state_q     <= S_PUSH;
            iid_o       <= swi_id_i;
            busy_o      <= 1'b1;
            ie_clr_o    <= 1'b1;
            mem_req_o   <= 1'b1;
            mem_we_o    <= 1'b1;
            mem_addr_o  <= sp_dec;
            mem_wdata_o <= next_ip_i;
            sp_wr_o     <= 1'b1;
            sp_wdata_o  <= sp_dec;
          end else if (iret_i) begin
            state_q    <= S_RREQ;
            iid_o      <= '0;
            busy_o     <= 1'b1;
            mem_req_o  <= 1'b1;
            mem_addr_o <= sp_i;
          end
        end
        S_ACK1: state_q <= S_ACK2;
        S_ACK2: begin
          state_q     <= S_PUSH;
          ira_o       <= 1'b0;
          iid_o       <= DW'(io_data_i);
          mem_req_o   <= 1'b1;
          mem_we_o    <= 1'b1;
          mem_addr_o  <= sp_dec;
          mem_wdata_o <= next_ip_i;
          sp_wr_o     <= 1'b1;
          sp_wdata_o  <= sp_dec;
        end
        S_PUSH: begin
          state_q    <= S_VREQ;
          mem_req_o  <= 1'b1;
          mem_addr_o <= VEC_ADDR;
        end
        S_VREQ: state_q <= S_VDATA;
        S_VDATA: begin
          state_q    <= S_IDLE;
          busy_o     <= 1'b0;
          ip_wr_o    <= 1'b1;
          ip_wdata_o <= mem_rdata_i;
        end
        S_RREQ: state_q <= S_RDATA;
        S_RDATA: begin
          state_q    <= S_IDLE;
          busy_o     <= 1'b0;
          ip_wr_o    <= 1'b1;
          ip_wdata_o <= mem_rdata_i;
          sp_wr_o    <= 1'b1;
          sp_wdata_o <= sp_inc;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/int_sequencer.sv
module int_sequencer #(
  parameter int AW   = 16,
  parameter int DW   = 16,
  parameter int IDW  = 8,
  parameter int STEP = 2,
  parameter logic [AW-1:0] VEC_ADDR = 16'hFFFC
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           irq_i,
  input  logic           fetch_req_i,
  input  logic           swi_i,
  input  logic [DW-1:0]  swi_id_i,
  input  logic           iret_i,
  input  logic           ie_i,
  input  logic [AW-1:0]  sp_i,
  input  logic [AW-1:0]  next_ip_i,
  input  logic [IDW-1:0] io_data_i,
  input  logic [DW-1:0]  mem_rdata_i,
  output logic           int_take_o,
  output logic           ira_o,
  output logic           busy_o,
  output logic           ie_clr_o,
  output logic [DW-1:0]  iid_o,
  output logic           sp_wr_o,
  output logic [AW-1:0]  sp_wdata_o,
  output logic           ip_wr_o,
  output logic [AW-1:0]  ip_wdata_o,
  output logic           mem_req_o,
  output logic           mem_we_o,
  output logic [AW-1:0]  mem_addr_o,
  output logic [DW-1:0]  mem_wdata_o
);
  logic pend, idle;

  assign int_take_o = fetch_req_i && pend && idle;

  intseq_pending i_pending (
    .clk    (clk),
    .rst    (rst),
    .irq_i  (irq_i),
    .ie_i   (ie_i),
    .idle_i (idle),
    .take_i (int_take_o),
    .pend_o (pend)
  );

  intseq_fsm #(
    .AW(AW), .DW(DW), .IDW(IDW), .STEP(STEP), .VEC_ADDR(VEC_ADDR)
  ) i_fsm (
    .clk         (clk),
    .rst         (rst),
    .take_i      (int_take_o),
    .swi_i       (swi_i),
    .swi_id_i    (swi_id_i),
    .iret_i      (iret_i),
    .ie_i        (ie_i),
    .sp_i        (sp_i),
    .next_ip_i   (next_ip_i),
    .io_data_i   (io_data_i),
    .mem_rdata_i (mem_rdata_i),
    .idle_o      (idle),
    .ira_o       (ira_o),
    .busy_o      (busy_o),
    .ie_clr_o    (ie_clr_o),
    .iid_o       (iid_o),
    .sp_wr_o     (sp_wr_o),
    .sp_wdata_o  (sp_wdata_o),
    .ip_wr_o     (ip_wr_o),
    .ip_wdata_o  (ip_wdata_o),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o)
  );
endmodule

// File: rtl/intseq_chk.sv
module intseq_chk (
  input logic clk,
  input logic rst,
  input logic swi_i,
  input logic iret_i,
  input logic ie_i,
  input logic int_take_o,
  input logic ira_o,
  input logic busy_o,
  input logic ie_clr_o,
  input logic ip_wr_o,
  input logic mem_req_o
);
  p_take_starts_ack_r3: assert property (@(posedge clk) disable iff (rst)
    int_take_o |=> (ira_o && busy_o));

  p_ack_needs_take_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(ira_o) |-> $past(int_take_o));

  p_ack_two_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(ira_o) |=> ira_o);

  p_ack_not_three_r4: assert property (@(posedge clk) disable iff (rst)
    (ira_o && $past(ira_o)) |=> !ira_o);

  p_ack_no_mem_r4: assert property (@(posedge clk) disable iff (rst)
    ira_o |-> !mem_req_o);

  p_ip_load_ends_busy_r6: assert property (@(posedge clk) disable iff (rst)
    ip_wr_o |-> !busy_o);

  p_entry_clears_ie_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(ira_o) |-> ie_clr_o);

  p_swi_off_noop_r9: assert property (@(posedge clk) disable iff (rst)
    (swi_i && !ie_i && !busy_o && !int_take_o && !iret_i) |=> (!mem_req_o && !busy_o));
endmodule

bind int_sequencer intseq_chk i_chk (
  .clk        (clk),
  .rst        (rst),
  .swi_i      (swi_i),
  .iret_i     (iret_i),
  .ie_i       (ie_i),
  .int_take_o (int_take_o),
  .ira_o      (ira_o),
  .busy_o     (busy_o),
  .ie_clr_o   (ie_clr_o),
  .ip_wr_o    (ip_wr_o),
  .mem_req_o  (mem_req_o)
);

// File: tb/test_int_sequencer.sv
`timescale 1ns/1ps
module test_int_sequencer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        irq = 1'b0, fetch_req = 1'b0, swi = 1'b0, iret = 1'b0;
  logic [15:0] swi_id = '0, next_ip = '0;
  logic [7:0]  io_data = '0;
  logic [15:0] mem_rdata;
  logic        int_take, ira, busy, ie_clr, sp_wr, ip_wr, mem_req, mem_we;
  logic [15:0] iid, sp_wdata, ip_wdata, mem_addr, mem_wdata;

  // register file model
  logic [15:0] sp_r = 16'h0040, ip_r = '0;
  logic        ie_r = 1'b0;
  logic        ie_set = 1'b0, sp_set = 1'b0;
  logic [15:0] sp_set_val = '0;
  logic [15:0] mem [0:63];

  int total = 0, bad = 0;

  always #2 clk = ~clk;

  int_sequencer i_int_sequencer (
    .clk(clk), .rst(rst), .irq_i(irq), .fetch_req_i(fetch_req), .swi_i(swi),
    .swi_id_i(swi_id), .iret_i(iret), .ie_i(ie_r), .sp_i(sp_r),
    .next_ip_i(next_ip), .io_data_i(io_data), .mem_rdata_i(mem_rdata),
    .int_take_o(int_take), .ira_o(ira), .busy_o(busy), .ie_clr_o(ie_clr),
    .iid_o(iid), .sp_wr_o(sp_wr), .sp_wdata_o(sp_wdata), .ip_wr_o(ip_wr),
    .ip_wdata_o(ip_wdata), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata)
  );

  always @(posedge clk) begin
    if (sp_wr) sp_r <= sp_wdata;
    else if (sp_set) sp_r <= sp_set_val;
    if (ip_wr) ip_r <= ip_wdata;
    if (ie_clr) ie_r <= 1'b0;
    else if (ie_set) ie_r <= 1'b1;
    if (mem_req) begin
      if (mem_we) mem[mem_addr[6:1]] <= mem_wdata;
      else mem_rdata <= mem[mem_addr[6:1]];
    end
  end

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic enable_ie();
    ie_set = 1'b1; step(); ie_set = 1'b0;
  endtask

  task automatic t_reset();
    step(); step(); rst = 1'b0; step();
    chk("R1", "ira", {15'd0, ira}, 16'd0);
    chk("R1", "busy", {15'd0, busy}, 16'd0);
    chk("R1", "mem_req", {15'd0, mem_req}, 16'd0);
    chk("R1", "iid", iid, 16'd0);
    chk("R1", "wr strobes", {13'd0, ip_wr, sp_wr, ie_clr}, 16'd0);
    fetch_req = 1'b1; #0.5;
    chk("R1", "no pending after reset", {15'd0, int_take}, 16'd0);
    fetch_req = 1'b0;
  endtask

  task automatic t_dropped();
    irq = 1'b1; step(); step(); irq = 1'b0;
    enable_ie();
    fetch_req = 1'b1; #0.5;
    chk("R2", "disabled request dropped", {15'd0, int_take}, 16'd0);
    step(); fetch_req = 1'b0;
    chk("R2", "no ack for dropped", {15'd0, ira}, 16'd0);
  endtask

  task automatic t_hw();
    irq = 1'b1; step(); irq = 1'b0;
    next_ip = 16'h0204;
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R3", "no ack without boundary", {14'd0, ira, busy}, 16'd0);
    end
    fetch_req = 1'b1; #0.5;
    chk("R3", "take at boundary", {15'd0, int_take}, 16'd1);
    step(); fetch_req = 1'b0; io_data = 8'hAA;
    chk("R4", "ira cycle1", {15'd0, ira}, 16'd1);
    chk("R4", "no mem in ack", {15'd0, mem_req}, 16'd0);
    chk("R7", "ie_clr pulse", {15'd0, ie_clr}, 16'd1);
    chk("R6", "busy at ack", {15'd0, busy}, 16'd1);
    step(); io_data = 8'h5C;
    chk("R4", "ira cycle2", {15'd0, ira}, 16'd1);
    chk("R7", "ie cleared", {15'd0, ie_r}, 16'd0);
    step(); io_data = 8'h00;
    chk("R4", "ira off after two", {15'd0, ira}, 16'd0);
    chk("R4", "iid from second cycle", iid, 16'h005C);
    chk("R5", "push write", {14'd0, mem_req, mem_we}, 16'd3);
    chk("R5", "push addr", mem_addr, 16'h003E);
    chk("R5", "push data", mem_wdata, 16'h0204);
    chk("R5", "sp write", sp_wdata, 16'h003E);
    step();
    chk("R6", "vector read", {14'd0, mem_req, mem_we}, 16'd2);
    chk("R6", "vector addr", mem_addr, 16'hFFFC);
    chk("R5", "stack word", mem[31], 16'h0204);
    chk("R5", "sp updated", sp_r, 16'h003E);
    step();
    chk("R6", "busy before load", {15'd0, busy}, 16'd1);
    step();
    chk("R6", "ip load strobe", {15'd0, ip_wr}, 16'd1);
    chk("R6", "ip load value", ip_wdata, 16'h1234);
    chk("R6", "busy released", {15'd0, busy}, 16'd0);
  endtask

  task automatic t_iret(input logic [15:0] exp_ip, input logic [15:0] exp_sp);
    iret = 1'b1; step(); iret = 1'b0;
    chk("R10", "iid cleared", iid, 16'd0);
    chk("R10", "read at sp", {mem_addr[15:1], mem_we}, {exp_sp[15:1] - 15'd1, 1'b0});
    step(); step();
    chk("R10", "ip restore", {15'd0, ip_wr}, 16'd1);
    chk("R10", "ip value", ip_wdata, exp_ip);
    chk("R10", "sp pop", sp_wdata, exp_sp);
    step();
    chk("R10", "sp reg", sp_r, exp_sp);
  endtask

  task automatic t_swi_on();
    enable_ie();
    next_ip = 16'h0310; swi_id = 16'h0033;
    swi = 1'b1; step(); swi = 1'b0;
    chk("R8", "iid operand", iid, 16'h0033);
    chk("R8", "no ira", {15'd0, ira}, 16'd0);
    chk("R8", "push", {14'd0, mem_req, mem_we}, 16'd3);
    chk("R8", "push addr", mem_addr, 16'h003E);
    chk("R7", "ie_clr swi", {15'd0, ie_clr}, 16'd1);
    step(); step(); step();
    chk("R8", "vector load", ip_wdata, 16'h1234);
    chk("R8", "ip strobe", {15'd0, ip_wr}, 16'd1);
  endtask

  task automatic t_swi_off();
    swi = 1'b1; swi_id = 16'h0077; step(); swi = 1'b0;
    chk("R9", "no busy", {14'd0, busy, ira}, 16'd0);
    chk("R9", "no mem", {15'd0, mem_req}, 16'd0);
    chk("R9", "iid kept", iid, 16'd0);
  endtask

  task automatic t_held();
    int rises = 0;
    enable_ie();
    irq = 1'b1;
    for (int i = 0; i < 20; i++) begin
      fetch_req = (i % 4 == 1);
      step();
      if (ira && !busy) rises = rises + 100;
      if (ira && ie_clr) rises++;
    end
    fetch_req = 1'b0; irq = 1'b0;
    chk("R11", "single entry", 16'(rises), 16'd1);
    chk("R11", "ie left clear", {15'd0, ie_r}, 16'd0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    mem[62] = 16'h1234;
    t_reset();
    t_dropped();
    t_hw();
    t_iret(16'h0204, 16'h0040);
    t_swi_on();
    t_iret(16'h0310, 16'h0040);
    t_swi_off();
    t_held();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule